// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block forms the full-width product of two signed (two's complement) operands of WIDTH bits each. It uses one adder of WIDTH+1 bits and takes WIDTH clock cycles. A start pulse loads both operands. The block then examines one multiplier bit per cycle, starting from the least significant bit. For each bit it may add or subtract the multiplicand into an upper accumulator. It then shifts the whole accumulated value one place to the right, so the finished low product bits move into a lower register.

The multiplier's most significant bit carries negative weight, so its partial product is subtracted rather than added. This lets a negative multiplier work without negating either operand first. A single guard bit above the accumulator holds the sign of the running sum, and every right shift keeps it. After the final step the guard bit is dropped, and the accumulator followed by the lower register forms the 2*WIDTH-bit signed product.

The product output holds its value until the next operation is accepted. Busy marks the run, and a one-cycle done pulse marks the moment the product is valid.

Top module: `sgn_seq_mult`

## Requirements
- R1: While reset is active, and until the first accepted start, busy and done are 0 and product is all zeros.
- R2: A start seen on a rising edge while busy is 0 captures mcand_i and mplier_i on that edge, and busy reads 1 in the following cycle.
- R3: Done is a single-cycle pulse. It rises on the WIDTH-th rising edge after the accepting edge, and busy falls on that same edge.
- R4: When done is 1, product equals the 2*WIDTH-bit two's complement product of the captured multiplicand and multiplier.
- R5: A start that arrives while busy is 1 is ignored. The running result and the done timing remain those of the operation already in progress.
- R6: Changes on mcand_i and mplier_i after the accepting edge have no effect on the running operation.
- R7: Between done and the next accepted start, product keeps its value.
- R8: The step for the multiplier's sign bit subtracts the multiplicand. With WIDTH = 4, 6 times -5 gives product 8'hE2 (-30).
- R9: The most negative multiplicand times the most negative multiplier gives the positive value 2^(2*WIDTH-2). With WIDTH = 4, -8 times -8 gives 8'h40.
- R10: A negative multiplicand keeps its sign through every right shift. With WIDTH = 4, -8 times 7 gives 8'hC8 (-56).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin a multiplication, sampled on a rising edge |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when product is valid |
| product | output | 2*WIDTH | Signed product |

## Verification
Busy is due in the cycle that follows the accepting edge. Done and the valid product are due exactly WIDTH edges after that edge. The bench drives start in the falling-edge half of cycle c and stores each expected product with the due cycle c+WIDTH+1, counted in rising edges. A monitor samples on falling edges and compares the product and the cycle number when it pops each item. Ignored starts, operand changes during a run, and the product holding after done are all checked on the falling edges that fall between the stimulus and the next scheduled result.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // Sequencer state: waiting for a request, or stepping through multiplier bits.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smul_state_e;

endpackage

// File: rtl/smul_rst_sync.sv
// Asynchronous assertion, two-flop synchronous release of the active-low reset.
module smul_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/smul_ctrl.sv
// Step sequencer: accepts a request when idle, runs WIDTH steps, pulses done.
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic step_en,
  output logic last_step,
  output logic busy,
  output logic done
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  smul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;
  logic cnt_en;

  // Request qualification and step decode
  always_comb begin
    load_en   = (state_q == ST_IDLE) && start;
    step_en   = (state_q == ST_RUN);
    last_step = step_en && (cnt_q == LAST_IDX);
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done_d  = last_step;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_RUN: begin
        cnt_en = 1'b1;
        if (last_step) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;

endmodule

// File: rtl/smul_step.sv
// One add-or-subtract-then-shift step on the guard bit, accumulator and low register.
module smul_step #(
  parameter int WIDTH = 8
) (
  input  logic             guard_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] low_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic             sign_step_i,
  output logic             guard_o,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] low_o
);

  localparam int EW = WIDTH + 1;

  logic [EW-1:0] run_ext;
  logic [EW-1:0] mc_ext;
  logic [EW-1:0] addend;
  logic [EW-1:0] sum;

  always_comb begin
    run_ext = {guard_i, acc_i};
    mc_ext  = {mcand_i[WIDTH-1], mcand_i};
    if (!low_i[0]) begin
      addend = '0;
    end else if (sign_step_i) begin
      addend = ~mc_ext + 1'b1;   // sign bit of the multiplier has negative weight
    end else begin
      addend = mc_ext;
    end
    sum = run_ext + addend;
    // arithmetic right shift across guard, accumulator and low register
    guard_o = sum[EW-1];
    acc_o   = sum[EW-1:1];
    low_o   = {sum[0], low_i[WIDTH-1:1]};
  end

endmodule

// File: rtl/smul_dp.sv
// Operand and product registers around the step logic.
module smul_dp #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               step_en,
  input  logic               last_step,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] product
);

  logic             guard_q, guard_d, guard_s;
  logic [WIDTH-1:0] acc_q, acc_d, acc_s;
  logic [WIDTH-1:0] low_q, low_d, low_s;
  logic [WIDTH-1:0] mc_q;
  logic             run_en;

  smul_step #(.WIDTH(WIDTH)) u_step (
    .guard_i     (guard_q),
    .acc_i       (acc_q),
    .low_i       (low_q),
    .mcand_i     (mc_q),
    .sign_step_i (last_step),
    .guard_o     (guard_s),
    .acc_o       (acc_s),
    .low_o       (low_s)
  );

  // Next-value selection: load clears the sum and parks the multiplier in the low register
  always_comb begin
    run_en  = load_en || step_en;
    guard_d = guard_s;
    acc_d   = acc_s;
    low_d   = low_s;
    if (load_en) begin
      guard_d = 1'b0;
      acc_d   = '0;
      low_d   = mplier_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q <= 1'b0;
      acc_q   <= '0;
      low_q   <= '0;
    end else if (run_en) begin
      guard_q <= guard_d;
      acc_q   <= acc_d;
      low_q   <= low_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q <= '0;
    end else if (load_en) begin
      mc_q <= mcand_i;
    end
  end

  assign product = {acc_q, low_q};

endmodule

// File: rtl/sgn_seq_mult.sv
module sgn_seq_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  logic rst_sync_n;
  logic load_en;
  logic step_en;
  logic last_step;

  smul_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .load_en   (load_en),
    .step_en   (step_en),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  smul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_en   (load_en),
    .step_en   (step_en),
    .last_step (last_step),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product   (product)
  );

endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [WIDTH-1:0]   mcand_i,
  input logic [WIDTH-1:0]   mplier_i,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] exp_q;
  int unsigned   cyc_q;
  logic          accept;
  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;

  assign accept = start && !busy;
  assign a_ext  = {{WIDTH{mcand_i[WIDTH-1]}}, mcand_i};
  assign b_ext  = {{WIDTH{mplier_i[WIDTH-1]}}, mplier_i};

  // Independent reference: full signed product of the operands seen at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      cyc_q <= 0;
    end else begin
      if (accept) begin
        exp_q <= a_ext * b_ext;
        cyc_q <= 0;
      end else if (busy) begin
        cyc_q <= cyc_q + 1;
      end
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_q == WIDTH) && !busy);

  // operands are taken only on acceptance, so this also covers R5 and R6
  p_product_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == exp_q));

  p_product_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

endmodule

bind sgn_seq_mult smul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (start),
  .mcand_i  (mcand_i),
  .mplier_i (mplier_i),
  .busy     (busy),
  .done     (done),
  .product  (product)
);

// File: tb/sgn_seq_mult_bench.sv
`timescale 1ns/1ps
module sgn_seq_mult_bench;

  localparam int W  = 4;
  localparam int PW = 2 * W;

  typedef struct {
    logic [PW-1:0] prod;
    int            due;
    string         tag;
  } exp_item_t;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  mcand_i;
  logic [W-1:0]  mplier_i;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  logic done_prev = 1'b0;
  exp_item_t sb_q[$];

  sgn_seq_mult #(.WIDTH(W)) u_sgn_seq_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .busy     (busy),
    .done     (done),
    .product  (product)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Driver: called at a falling edge; waits for idle, issues a request, queues its result
  task automatic run_op(input int a, input int b, input string tag);
    int p;
    exp_item_t it;
    while (busy) @(negedge clk);
    start    = 1'b1;
    mcand_i  = W'(a);
    mplier_i = W'(b);
    p        = a * b;
    it.prod  = p[PW-1:0];
    it.due   = cyc + W + 1;
    it.tag   = tag;
    sb_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", longint'(busy), 1);
  endtask

  // Monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        check(!done_prev, "R3 done single cycle", longint'(done_prev), 0);
        check(!busy, "R3 busy low with done", longint'(busy), 0);
        if (sb_q.size() == 0) begin
          check(1'b0, "R3 unexpected done", 1, 0);
        end else begin
          exp_item_t it;
          it = sb_q.pop_front();
          check(cyc == it.due, {it.tag, " done timing R3"}, longint'(cyc), longint'(it.due));
          check(product == it.prod, {it.tag, " product"}, longint'(product), longint'(it.prod));
        end
      end
      done_prev <= done;
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    mcand_i  = '0;
    mplier_i = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", longint'(busy), 0);
    check(done == 1'b0, "R1 done in reset", longint'(done), 0);
    check(product == '0, "R1 product in reset", longint'(product), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(product == '0 && !busy, "R1 state after release", longint'(product), 0);

    run_op(6, -5, "R8");      // expect 8'hE2
    run_op(-8, -8, "R9");     // expect 8'h40
    run_op(-8, 7, "R10");     // expect 8'hC8

    // R5: second request while running is dropped
    run_op(3, 5, "R5");
    start    = 1'b1;
    mcand_i  = 4'd7;
    mplier_i = 4'd7;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R5 still busy", longint'(busy), 1);

    // R6: operand inputs move during the run
    run_op(-3, 6, "R6");
    mcand_i  = 4'hF;
    mplier_i = 4'h8;
    @(negedge clk);
    mcand_i  = 4'h1;
    mplier_i = 4'h7;

    // R7: product holds after done while inputs wander
    run_op(5, -7, "R7");
    while (!done) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      mcand_i  = W'(k);
      mplier_i = W'(k + 3);
      @(negedge clk);
      check(product == 8'hDD, "R7 product holds", longint'(product), 8'hDD);
    end

    // R4: every operand pair, issued back to back
    for (int a = -(1 << (W - 1)); a < (1 << (W - 1)); a++) begin
      for (int b = -(1 << (W - 1)); b < (1 << (W - 1)); b++) begin
        run_op(a, b, "R4");
      end
    end

    while (busy || sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R3 all results seen", longint'(sb_q.size()), 0);
    finish_run();
  end

endmodule